// File: doc/BRIEF.md
# Sequential unsigned 16-by-8 divider

This block is a multi-cycle execution unit that divides a 16-bit unsigned dividend by an 8-bit unsigned divisor. A one-cycle start pulse hands it both operands. The block then runs a restoring shift-subtract loop that yields the full 16-bit quotient. It returns a 16-bit result word: the 8-bit remainder sits in the high byte and the low 8 bits of the quotient sit in the low byte. It also returns four status flags: overflow, carry, zero and sign.

The time from start to done is fixed. A normal divide always takes the same number of cycles. A zero divisor is detected when start is accepted and finishes on a shorter fixed schedule. A single-cycle done pulse marks completion. The result and flags then hold until the next divide completes. The decimal-adjust and half-carry flag bits of the surrounding status word pass straight through. The reset input is asserted asynchronously and released synchronously inside the block.

Top module: `udiv16x8_unit`

## Requirements
- R1: For a nonzero divisor and a quotient below 256, result bits [15:8] hold the remainder and bits [7:0] hold the quotient.
- R2: flag_v_o is 1 when the divisor is zero or the quotient is 256 or more, and 0 otherwise.
- R3: flag_c_o is 1 only when the divisor is nonzero and the quotient lies between 256 and 511 inclusive. flag_c_o is never 1 while flag_v_o is 0.
- R4: flag_z_o is 1 when the divisor is zero or bits [7:0] of the quotient are all zero, and 0 otherwise.
- R5: flag_s_o equals bit 7 of the quotient for a nonzero divisor, and is 0 for a zero divisor.
- R6: With a nonzero divisor, done_o is high in the cycle after the 26th rising edge, where the edge that samples start_i counts as edge 1.
- R7: With a zero divisor, done_o is high in the cycle after the 10th rising edge, counted the same way. The result word then equals the dividend unchanged.
- R8: done_o is high for exactly one cycle. The result and flags stay unchanged from that cycle until the next divide completes.
- R9: A start_i pulse that arrives while busy_o is high is ignored. It changes neither the completion time nor the result of the divide in progress.
- R10: dec_adj_o follows dec_adj_i and half_cy_o follows half_cy_i at all times.
- R11: After reset, busy_o, done_o, result_o and all four computed flags are 0.
- R12: busy_o rises on the edge that accepts start_i. It falls on the same edge that raises done_o, and it is never high together with done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Starts a divide when the unit is idle |
| dividend_i | input | 16 | Unsigned dividend, sampled with start_i |
| divisor_i | input | 8 | Unsigned divisor, sampled with start_i |
| dec_adj_i | input | 1 | Decimal-adjust flag to pass through |
| half_cy_i | input | 1 | Half-carry flag to pass through |
| busy_o | output | 1 | High while a divide is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Remainder in [15:8], quotient low byte in [7:0] |
| flag_c_o | output | 1 | Carry: quotient in 256..511 |
| flag_z_o | output | 1 | Zero: zero divisor or zero quotient low byte |
| flag_s_o | output | 1 | Sign: quotient bit 7 |
| flag_v_o | output | 1 | Overflow: zero divisor or quotient of 256 or more |
| dec_adj_o | output | 1 | Copy of dec_adj_i |
| half_cy_o | output | 1 | Copy of half_cy_i |

## Verification
A wrong partial remainder in the shift-subtract loop stays hidden until the done pulse. It then shows up as a wrong byte or a wrong carry or overflow flag, so every case compares the whole result word and all four flags against arithmetic done in the bench. A wrong latency count shows up as done arriving on the wrong edge, and the bench counts edges from the accepting edge. A start pulse that leaks through during a divide changes either the completion edge or the result, and both are checked. The edge-case quotients chosen are 255, 256, 384 and 65535, plus a zero divisor.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
  localparam int unsigned DIVIDEND_W = 16;
  localparam int unsigned DIVISOR_W  = 8;
  localparam int unsigned LAT_NORMAL = 26;
  localparam int unsigned LAT_ZERO   = 10;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
  } div_flags_t;
endpackage

// File: rtl/udiv_ctrl.sv
module udiv_ctrl #(
  parameter int unsigned LAT_NORM = 26,
  parameter int unsigned LAT_DIVZ = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic divz_i,
  output logic busy_o,
  output logic load_o,
  output logic finish_o,
  output logic done_o,
  output logic divz_o
);
  localparam int unsigned CW = $clog2(LAT_NORM + 1);

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic          divz_q, divz_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    load_o   = start_i && !busy_q;
    finish_o = busy_q && (cnt_q == CW'(1));
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    divz_d   = divz_q;
    done_d   = finish_o;
    if (load_o) begin
      busy_d = 1'b1;
      divz_d = divz_i;
      cnt_d  = divz_i ? CW'(LAT_DIVZ - 1) : CW'(LAT_NORM - 1);
    end else if (busy_q) begin
      cnt_d = cnt_q - CW'(1);
      if (finish_o) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      divz_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      divz_q <= divz_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign divz_o = divz_q;

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_busy_done_apart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
  assert_accept_sets_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && !done_q));
  assert_busy_not_cut_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q > CW'(1)) |=> busy_q);
endmodule

// File: rtl/udiv_datapath.sv
module udiv_datapath #(
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          run_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [SW-1:0] divisor_i,
  output logic [DW-1:0] quo_o,
  output logic [SW-1:0] rem_o
);
  localparam int unsigned STW = $clog2(DW + 1);

  logic [DW-1:0]  quo_q, quo_d;
  logic [SW-1:0]  rem_q, rem_d;
  logic [SW-1:0]  div_q, div_d;
  logic [STW-1:0] left_q, left_d;
  logic [SW:0]    shifted;
  logic           fits;
  logic           step_en;

  always_comb begin
    step_en = run_i && (left_q != '0);
    shifted = {rem_q, quo_q[DW-1]};
    fits    = shifted >= {1'b0, div_q};
    quo_d   = quo_q;
    rem_d   = rem_q;
    div_d   = div_q;
    left_d  = left_q;
    if (load_i) begin
      quo_d  = dividend_i;
      rem_d  = '0;
      div_d  = divisor_i;
      left_d = STW'(DW);
    end else if (step_en) begin
      quo_d  = {quo_q[DW-2:0], fits};
      rem_d  = fits ? SW'(shifted - {1'b0, div_q}) : shifted[SW-1:0];
      left_d = left_q - STW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q  <= '0;
      rem_q  <= '0;
      div_q  <= '0;
      left_q <= '0;
    end else begin
      quo_q  <= quo_d;
      rem_q  <= rem_d;
      div_q  <= div_d;
      left_q <= left_d;
    end
  end

  assign quo_o = quo_q;
  assign rem_o = rem_q;

  assert_rem_below_div_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (div_q != '0) |-> (rem_q < div_q));
endmodule

// File: rtl/udiv_flags.sv
module udiv_flags
  import udiv_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned SW = 8
) (
  input  logic          divz_i,
  input  logic [DW-1:0] quo_i,
  input  logic [SW-1:0] rem_i,
  output logic [DW-1:0] word_o,
  output div_flags_t    flags_o
);
  logic big, in_carry_band;

  always_comb begin
    big           = quo_i[DW-1:SW] != '0;
    in_carry_band = (quo_i[DW-1:SW+1] == '0) && quo_i[SW];
    if (divz_i) begin
      word_o    = quo_i;
      flags_o.v = 1'b1;
      flags_o.c = 1'b0;
      flags_o.z = 1'b1;
      flags_o.s = 1'b0;
    end else begin
      word_o    = {rem_i, quo_i[SW-1:0]};
      flags_o.v = big;
      flags_o.c = in_carry_band;
      flags_o.z = quo_i[SW-1:0] == '0;
      flags_o.s = quo_i[SW-1];
    end
  end
endmodule

// File: rtl/udiv16x8_unit.sv
module udiv16x8_unit
  import udiv_pkg::*;
#(
  parameter int unsigned DW       = DIVIDEND_W,
  parameter int unsigned SW       = DIVISOR_W,
  parameter int unsigned LAT_NORM = LAT_NORMAL,
  parameter int unsigned LAT_DIVZ = LAT_ZERO
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [SW-1:0] divisor_i,
  input  logic          dec_adj_i,
  input  logic          half_cy_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] result_o,
  output logic          flag_c_o,
  output logic          flag_z_o,
  output logic          flag_s_o,
  output logic          flag_v_o,
  output logic          dec_adj_o,
  output logic          half_cy_o
);
  logic          rst_meta_q, rst_sync_q;
  logic          load, finish, divz_run, run;
  logic [DW-1:0] quo;
  logic [SW-1:0] rem;
  logic [DW-1:0] word;
  div_flags_t    flags;
  logic [DW-1:0] result_q;
  div_flags_t    flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  udiv_ctrl #(.LAT_NORM(LAT_NORM), .LAT_DIVZ(LAT_DIVZ)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_q), .start_i(start_i),
    .divz_i(divisor_i == '0), .busy_o(busy_o), .load_o(load),
    .finish_o(finish), .done_o(done_o), .divz_o(divz_run)
  );

  assign run = busy_o && !divz_run;

  udiv_datapath #(.DW(DW), .SW(SW)) u_dp (
    .clk(clk), .rst_n(rst_sync_q), .load_i(load), .run_i(run),
    .dividend_i(dividend_i), .divisor_i(divisor_i),
    .quo_o(quo), .rem_o(rem)
  );

  udiv_flags #(.DW(DW), .SW(SW)) u_flags (
    .divz_i(divz_run), .quo_i(quo), .rem_i(rem),
    .word_o(word), .flags_o(flags)
  );

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      result_q <= '0;
      flags_q  <= '0;
    end else if (finish) begin
      result_q <= word;
      flags_q  <= flags;
    end
  end

  assign result_o  = result_q;
  assign flag_c_o  = flags_q.c;
  assign flag_z_o  = flags_q.z;
  assign flag_s_o  = flags_q.s;
  assign flag_v_o  = flags_q.v;
  assign dec_adj_o = dec_adj_i;
  assign half_cy_o = half_cy_i;

  assert_carry_needs_v_R3: assert property (@(posedge clk) disable iff (!rst_sync_q)
    flag_c_o |-> flag_v_o);
  assert_sign_excludes_zero_R5: assert property (@(posedge clk) disable iff (!rst_sync_q)
    flag_s_o |-> !flag_z_o);
  assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    busy_o |-> ($stable(result_o) && $stable(flags_q)));
  assert_hold_after_done_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    done_o |=> $stable(result_o));
endmodule

// File: tb/tb_udiv16x8_unit.sv
module tb_udiv16x8_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] dividend_i = '0;
  logic [7:0]  divisor_i = '0;
  logic        dec_adj_i = 1'b0;
  logic        half_cy_i = 1'b0;
  logic        busy_o, done_o, flag_c_o, flag_z_o, flag_s_o, flag_v_o;
  logic        dec_adj_o, half_cy_o;
  logic [15:0] result_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  udiv16x8_unit dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dividend_i(dividend_i),
    .divisor_i(divisor_i), .dec_adj_i(dec_adj_i), .half_cy_i(half_cy_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
    .flag_c_o(flag_c_o), .flag_z_o(flag_z_o), .flag_s_o(flag_s_o),
    .flag_v_o(flag_v_o), .dec_adj_o(dec_adj_o), .half_cy_o(half_cy_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Pulse start, optionally a second start mid-flight; return edges to done.
  task automatic launch(input logic [15:0] a, input logic [7:0] b,
                        input int extra_at, output int lat);
    @(negedge clk);
    dividend_i = a;
    divisor_i  = b;
    start_i    = 1'b1;
    @(posedge clk);
    lat = 1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R12 busy after accept", {31'd0, busy_o}, 32'd1);
    while (done_o !== 1'b1 && lat < 60) begin
      if (lat == extra_at) begin
        dividend_i = 16'h0011;
        divisor_i  = 8'h00;
        start_i    = 1'b1;
      end
      @(posedge clk);
      lat++;
      @(negedge clk);
      start_i = 1'b0;
    end
    check(busy_o === 1'b0, "R12 busy low with done", {31'd0, busy_o}, 32'd0);
  endtask

  task automatic expect_div(input logic [15:0] a, input logic [7:0] b, input int lat,
                            input string tag);
    int q, r;
    logic ev, ec, ez, es;
    q  = (b == 0) ? 0 : int'(a) / int'(b);
    r  = (b == 0) ? 0 : int'(a) % int'(b);
    ev = (b == 0) || (q >= 256);
    ec = (b != 0) && (q >= 256) && (q <= 511);
    ez = (b == 0) || ((q & 255) == 0);
    es = (b != 0) && (((q >> 7) & 1) == 1);
    if (b == 0) begin
      check(lat == 10, {tag, " R7 latency"}, lat, 10);
      check(result_o === a, {tag, " R7 result"}, result_o, a);
    end else begin
      check(lat == 26, {tag, " R6 latency"}, lat, 26);
      if (!ev)
        check(result_o === 16'((r << 8) | q), {tag, " R1 result"}, result_o,
              (r << 8) | q);
    end
    check(flag_v_o === ev, {tag, " R2 V"}, flag_v_o, ev);
    check(flag_c_o === ec, {tag, " R3 C"}, flag_c_o, ec);
    check(flag_z_o === ez, {tag, " R4 Z"}, flag_z_o, ez);
    check(flag_s_o === es, {tag, " R5 S"}, flag_s_o, es);
  endtask

  task automatic t_reset();
    check(busy_o === 1'b0 && done_o === 1'b0, "R11 busy/done", {busy_o, done_o}, 0);
    check(result_o === 16'h0, "R11 result", result_o, 0);
    check({flag_c_o, flag_z_o, flag_s_o, flag_v_o} === 4'b0, "R11 flags",
          {flag_c_o, flag_z_o, flag_s_o, flag_v_o}, 0);
  endtask

  task automatic t_div(input logic [15:0] a, input logic [7:0] b, input string tag);
    int lat;
    launch(a, b, -1, lat);
    expect_div(a, b, lat, tag);
  endtask

  task automatic t_hold();
    int lat;
    logic [15:0] keep;
    launch(16'h1003, 8'h40, -1, lat);
    keep = result_o;
    @(negedge clk);
    check(done_o === 1'b0, "R8 done one cycle", {31'd0, done_o}, 0);
    repeat (5) @(negedge clk);
    check(result_o === keep, "R8 result held", result_o, keep);
  endtask

  task automatic t_busy_start();
    int lat;
    launch(16'h0C35, 8'h07, 6, lat);
    expect_div(16'h0C35, 8'h07, lat, "R9 start while busy");
  endtask

  task automatic t_pass();
    @(negedge clk);
    dec_adj_i = 1'b1;
    half_cy_i = 1'b0;
    #1;
    check({dec_adj_o, half_cy_o} === 2'b10, "R10 pass 10", {dec_adj_o, half_cy_o}, 2);
    dec_adj_i = 1'b0;
    half_cy_i = 1'b1;
    #1;
    check({dec_adj_o, half_cy_o} === 2'b01, "R10 pass 01", {dec_adj_o, half_cy_o}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_div(16'h1003, 8'h40, "ex1");
    t_div(16'h1003, 8'h20, "ex2");
    t_div(16'h1003, 8'h80, "ex3");
    t_div(16'h0005, 8'h09, "zero quotient");
    t_div(16'hFEFF, 8'hFF, "quotient 255");
    t_div(16'h0100, 8'h01, "quotient 256");
    t_div(16'h0300, 8'h02, "quotient 384");
    t_div(16'hFFFF, 8'h01, "quotient 65535");
    t_div(16'hBEEF, 8'h00, "divide by zero");
    t_div(16'h0000, 8'h05, "zero dividend");
    t_hold();
    t_busy_start();
    t_pass();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule